// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for every beat of a four-beat burst. A load strobe captures a full external address and clears the beat count. Each later advance steps the two low address bits through a four-word group, and the bits above them keep the loaded value. A static order select picks between two stepping rules. The interleaved rule flips low bits according to the beat count. The linear rule counts upward and wraps inside the aligned group of four.

When neither load nor advance is asserted, the address and beat index stay where they are, which suspends the burst. A load may arrive at any cycle, including in the middle of a burst. Advancing past the fourth beat keeps cycling through the same group and never carries into the upper bits. Reset is synchronous and active high, and it clears both the address and the beat index to zero.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `addr` and `beat` become zero on that edge.
- R2: When `load` is high at a rising edge, `addr` takes `ext_addr` and `beat` takes 0. Load takes priority over `adv_n` and over hold.
- R3: When `load` is low and `adv_n` is low at a rising edge, `beat` increases by one modulo 4.
- R4: When `load` is low and `adv_n` is high, `addr` and `beat` keep their values (suspend).
- R5: Bits above bit 1 of `addr` always equal the most recently loaded address bits and never change on an advance.
- R6: With `order_sel` = 1 (interleaved), `addr[1:0]` equals the loaded offset XOR `beat`. For a start offset of 01 this gives 01, 00, 11, 10.
- R7: With `order_sel` = 0 (linear), `addr[1:0]` equals the loaded offset plus `beat`, modulo 4. For a start offset of 10 this gives 10, 11, 00, 01.
- R8: After the fourth beat, further advances continue to wrap within the same group of four, so the fifth address equals the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Begin-burst strobe that captures `ext_addr` |
| adv_n | input | 1 | Advance to the next beat, active low |
| order_sel | input | 1 | 1 selects interleaved order, 0 selects linear order (static) |
| ext_addr | input | AW | External start address |
| addr | output | AW | Current burst word address |
| beat | output | 2 | Beat index within the burst |

## Verification
A load and an active advance can fall in the same cycle. The bench provokes this by asserting `load` while `adv_n` is low, both in directed steps and in random stimulus. The bench judges it by expecting the freshly loaded address with beat 0, and not the stepped address. Hold and reload happen in the middle of bursts, for all four start offsets and in both orderings.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv_n,
  input  logic          order_sel,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] addr,
  output logic [1:0]    beat
);
  localparam int HW = AW - 2;

  logic [HW-1:0] base_q;
  logic [1:0]    start_q;
  logic [1:0]    cnt_q;
  logic [1:0]    low;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      base_q  <= ext_addr[AW-1:2];
      start_q <= ext_addr[1:0];
      cnt_q   <= '0;
    end else if (!adv_n) begin
      cnt_q   <= cnt_q + 2'd1;
    end
  end

  assign low  = order_sel ? (start_q ^ cnt_q) : (start_q + cnt_q);
  assign addr = {base_q, low};
  assign beat = cnt_q;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (addr == '0 && beat == 2'd0)); // R1
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr == $past(ext_addr) && beat == 2'd0)); // R2
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n) |=> (beat == $past(beat) + 2'd1)); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n && $stable(order_sel)) |=> $stable(addr) && $stable(beat)); // R4
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n) |=> addr[AW-1:2] == $past(addr[AW-1:2])); // R5
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst = 1, load = 0, adv_n = 1, order_sel = 1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] addr;
  logic [1:0] beat;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [AW-1:0] m_start;
  logic [1:0] m_cnt;

  burst_addr_seq #(.AW(AW)) uut (.clk(clk), .rst(rst), .load(load), .adv_n(adv_n),
    .order_sel(order_sel), .ext_addr(ext_addr), .addr(addr), .beat(beat));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] s, logic [1:0] c, logic il);
    logic [1:0] lo;
    lo = il ? (s[1:0] ^ c) : (s[1:0] + c);
    return {s[AW-1:2], lo};
  endfunction

  task automatic check(string req);
    logic [AW-1:0] e;
    e = exp_addr(m_start, m_cnt, order_sel);
    checks++;
    if (addr !== e || beat !== m_cnt) begin
      errors++;
      $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d", req, addr, beat, e, m_cnt);
    end
  endtask

  task automatic step(logic l, logic an, logic [AW-1:0] a, string req);
    load = l; adv_n = an; ext_addr = a;
    @(posedge clk);
    if (rst) begin m_start = '0; m_cnt = '0; end
    else if (l) begin m_start = a; m_cnt = '0; end
    else if (!an) m_cnt = m_cnt + 2'd1;
    #(CLK_PERIOD/4);
    check(req);
  endtask

  initial begin
    m_start = '0; m_cnt = '0;
    @(posedge clk); #(CLK_PERIOD/4);
    check("R1 reset");
    rst = 0;
    for (int m = 0; m < 2; m++) begin
      order_sel = m[0];
      for (int off = 0; off < 4; off++) begin
        step(1, 1, 16'hA5C0 | 16'(off), "R2 load");
        for (int b = 0; b < 5; b++) step(0, 0, 16'h0, m ? "R6 interleaved/R5" : "R7 linear/R5");
        step(0, 1, 16'hFFFF, "R4 hold");
        step(0, 0, 16'h0, "R8 wrap");
      end
    end
    order_sel = 0;
    step(1, 1, 16'h1232, "R7 start 10");
    step(0, 0, 0, "R7 11"); step(0, 0, 0, "R7 00"); step(0, 0, 0, "R7 01");
    step(0, 0, 0, "R8 back to 10");
    step(1, 0, 16'h7771, "R2 load beats advance");
    order_sel = 1;
    step(0, 0, 0, "R6 01->00"); step(0, 0, 0, "R6 11"); step(0, 0, 0, "R6 10");
    step(0, 0, 0, "R3 wrap count");
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      if (i % 100 == 0) order_sel = $urandom & 1;
      step(($urandom % 5) == 0, $urandom & 1, 16'($urandom), "R3/R4/R2 random");
    end
    rst = 1;
    step(1, 0, 16'hBEEF, "R1 reset priority");
    rst = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule